// File: doc/BRIEF.md
# Processor Counter/Timer Channel with User Mode

This block is one per-processor counter/timer channel. An external mode bit picks its personality. With the bit low it is an interval timer: a counter that advances on each 500 ns tick and, on reaching a programmed limit, restarts from zero, sets a reached flag and raises its interrupt. With the bit high it is a 54-bit free-running user counter. Software can preset it, start it and stop it, and it never interrupts.

Software reaches the channel through a 32-bit register port with four word slots, selected by `reg_sel` (0 to 3, standing for byte offsets 0x0, 0x4, 0x8 and 0xC). The counter sits at bit 9 and up of each word, so the low nine bits of every count word read as zero. Slots 0 and 1 change meaning with the mode. In counter mode they are the limit and the counter. In user mode they are the high and low halves of the user count. Read data is registered and appears one clock after the read strobe.

The mode bit comes from a system-wide mode register outside this block. The interrupt is routed to a processor outside this block.

Top module: `cpu_tmr_chan`

## Requirements
- R1: After synchronous reset the channel is in counter mode with limit 0, count 0, reached flag clear, running flag set and `irq` low.
- R2: In counter mode each tick adds one to the 22-bit count. When the incremented count equals a non-zero limit, the count returns to 0 and both the reached flag and `irq` are set. With limit 0 the count runs freely and never sets the reached flag.
- R3: In counter mode a read of slot 0 returns the limit in bits 30:9, with all other bits zero, and clears both the reached flag and `irq`. A read of slot 1 returns the reached flag in bit 31 and the count in bits 30:9. If a tick sets the reached flag in the same cycle as such a read, the flag stays set.
- R4: In counter mode a write to slot 0 loads the limit from bits 30:9, resets the count to 0 and drops `irq`. A write to slot 1 is ignored.
- R5: In either mode a write to slot 2 loads the limit from bits 30:9 and leaves the count unchanged.
- R6: A read of slot 3 returns the running flag in bit 0. A write to slot 3 in user mode sets the running flag from bit 0. In counter mode such a write is ignored and the running flag stays set.
- R7: On a rise of the mode bit the channel drops `irq`, clears the running flag and sets the limit to all ones, which reads back as 0x7FFFFE00. User mode takes effect on the next clock.
- R8: On a fall of the mode bit the channel sets the running flag and clears the count and the reached flag. Counter mode takes effect on the next clock.
- R9: In user mode a read of slot 0 returns the reached flag in bit 31 and user count bits 53:23 in bits 30:0. A read of slot 1 returns user count bits 22:0 in bits 31:9, and zero in bits 8:0.
- R10: In user mode a write to slot 0 loads user count bits 53:23 from data bits 30:0. A write to slot 1 loads user count bits 22:0 from data bits 31:9. Either write clears the reached flag.
- R11: In user mode, while running, each tick adds one to the 54-bit count with full carry. From all ones the count wraps to 0 and sets the reached flag. `irq` is never high in user mode. While stopped, ticks have no effect.
- R12: A word load in user mode takes effect at the next clock edge and wins over a tick in the same cycle.
- R13: `rdata` changes only on the clock edge that follows a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe for each 500 ns period |
| user_mode | input | 1 | Mode bit for this channel: 1 selects user mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Word slot, 0 to 3 (byte offsets 0x0 to 0xC) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt, counter mode only |

## Verification
The hardest situations to reach from the ports are the full-width wrap of the 54-bit user counter and the carry from the low word into the high word. Both would take far too many ticks to reach by counting. The stimulus uses the user-mode word loads to place the count one or two ticks below all ones, or at the top of the low half. It then starts the counter and sends single ticks. A pending counter-mode interrupt is also built up on purpose just before the mode bit rises, so that the entry side effects on `irq` can be seen.

// File: rtl/pct_pkg.sv
package pct_pkg;
  // Word slot decode; slot order is fixed because software addresses it.
  typedef enum logic [1:0] {
    IDX_HI_LIM   = 2'd0,
    IDX_LO_CNT   = 2'd1,
    IDX_LIM_KEEP = 2'd2,
    IDX_STAT     = 2'd3
  } pct_idx_e;
endpackage

// File: rtl/pct_mode.sv
module pct_mode (
  input  logic clk,
  input  logic rst,
  input  logic user_mode,
  output logic usr_q,
  output logic enter_usr,
  output logic enter_ctr
);
  always_ff @(posedge clk) begin
    if (rst) usr_q <= 1'b0;
    else     usr_q <= user_mode;
  end

  assign enter_usr = user_mode & ~usr_q;
  assign enter_ctr = ~user_mode & usr_q;
endmodule

// File: rtl/pct_core.sv
module pct_core
  import pct_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 9,
  parameter int UCNT_W = 54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usr_q,
  input  logic              enter_usr,
  input  logic              enter_ctr,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  pct_idx_e          idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [UCNT_W-1:0] cnt_q,
  output logic [WORD_W-FRAC_W-2:0] lim_q,
  output logic              reached_q,
  output logic              running_q,
  output logic              irq_q
);
  localparam int CNT_W = WORD_W - 1 - FRAC_W;
  localparam int LO_W  = WORD_W - FRAC_W;
  localparam int HI_W  = UCNT_W - LO_W;
  localparam logic [UCNT_W-1:0] UONE = UCNT_W'(1);
  localparam logic [CNT_W-1:0]  CONE = CNT_W'(1);

  logic [UCNT_W-1:0] cnt_n;
  logic [CNT_W-1:0]  lim_n, ctr_inc;
  logic              rch_n, run_n, irq_n;

  assign ctr_inc = cnt_q[CNT_W-1:0] + CONE;

  always_comb begin
    cnt_n = cnt_q;
    lim_n = lim_q;
    rch_n = reached_q;
    run_n = running_q;
    irq_n = irq_q;
    if (enter_usr) begin
      irq_n = 1'b0;
      run_n = 1'b0;
      lim_n = '1;
    end else if (enter_ctr) begin
      run_n = 1'b1;
      cnt_n = '0;
      rch_n = 1'b0;
    end else if (usr_q) begin
      irq_n = 1'b0;
      if (wr_en && idx == IDX_LIM_KEEP) lim_n = wdata[WORD_W-2:FRAC_W];
      if (wr_en && idx == IDX_STAT)     run_n = wdata[0];
      if (wr_en && idx == IDX_HI_LIM) begin
        cnt_n[UCNT_W-1:LO_W] = wdata[HI_W-1:0];
        rch_n = 1'b0;
      end else if (wr_en && idx == IDX_LO_CNT) begin
        cnt_n[LO_W-1:0] = wdata[WORD_W-1:FRAC_W];
        rch_n = 1'b0;
      end else if (tick && running_q) begin
        cnt_n = cnt_q + UONE;
        if (&cnt_q) rch_n = 1'b1;
      end
    end else begin
      if (rd_en && idx == IDX_HI_LIM) begin
        rch_n = 1'b0;
        irq_n = 1'b0;
      end
      if (wr_en && idx == IDX_LIM_KEEP) lim_n = wdata[WORD_W-2:FRAC_W];
      if (wr_en && idx == IDX_HI_LIM) begin
        lim_n = wdata[WORD_W-2:FRAC_W];
        cnt_n = '0;
        irq_n = 1'b0;
      end else if (tick) begin
        if (lim_q != '0 && ctr_inc == lim_q) begin
          cnt_n = '0;
          rch_n = 1'b1;
          irq_n = 1'b1;
        end else begin
          cnt_n = {{(UCNT_W-CNT_W){1'b0}}, ctr_inc};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      running_q <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      lim_q     <= lim_n;
      reached_q <= rch_n;
      running_q <= run_n;
      irq_q     <= irq_n;
    end
  end
endmodule

// File: rtl/pct_rdmux.sv
module pct_rdmux
  import pct_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 9,
  parameter int UCNT_W = 54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usr_q,
  input  logic              rd_en,
  input  pct_idx_e          idx,
  input  logic [UCNT_W-1:0] cnt_q,
  input  logic [WORD_W-FRAC_W-2:0] lim_q,
  input  logic              reached_q,
  input  logic              running_q,
  output logic [WORD_W-1:0] rdata
);
  localparam int CNT_W = WORD_W - 1 - FRAC_W;
  localparam int LO_W  = WORD_W - FRAC_W;

  logic [WORD_W-1:0] word_n;

  always_comb begin
    word_n = '0;
    case (idx)
      IDX_HI_LIM: word_n = usr_q ? {reached_q, cnt_q[UCNT_W-1:LO_W]}
                                 : {1'b0, lim_q, {FRAC_W{1'b0}}};
      IDX_LO_CNT: word_n = usr_q ? {cnt_q[LO_W-1:0], {FRAC_W{1'b0}}}
                                 : {reached_q, cnt_q[CNT_W-1:0], {FRAC_W{1'b0}}};
      IDX_STAT:   word_n = {{(WORD_W-1){1'b0}}, running_q};
      default:    word_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word_n;
  end
endmodule

// File: rtl/cpu_tmr_chan.sv
module cpu_tmr_chan
  import pct_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 9,
  parameter int UCNT_W = 54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = WORD_W - 1 - FRAC_W;

  pct_idx_e          idx;
  logic              usr_q, enter_usr, enter_ctr;
  logic [UCNT_W-1:0] cnt_q;
  logic [CNT_W-1:0]  lim_q;
  logic              reached_q, running;

  assign idx = pct_idx_e'(reg_sel);

  pct_mode u_mode (
    .clk(clk), .rst(rst), .user_mode(user_mode),
    .usr_q(usr_q), .enter_usr(enter_usr), .enter_ctr(enter_ctr)
  );

  pct_core #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .UCNT_W(UCNT_W)) u_core (
    .clk(clk), .rst(rst), .usr_q(usr_q), .enter_usr(enter_usr),
    .enter_ctr(enter_ctr), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .idx(idx), .wdata(wdata), .cnt_q(cnt_q), .lim_q(lim_q),
    .reached_q(reached_q), .running_q(running), .irq_q(irq)
  );

  pct_rdmux #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .UCNT_W(UCNT_W)) u_rd (
    .clk(clk), .rst(rst), .usr_q(usr_q), .rd_en(rd_en), .idx(idx),
    .cnt_q(cnt_q), .lim_q(lim_q), .reached_q(reached_q),
    .running_q(running), .rdata(rdata)
  );
endmodule

// File: rtl/pct_chk.sv
module pct_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              usr_q,
  input logic              irq,
  input logic              running,
  input logic              rd_en,
  input logic [1:0]        reg_sel,
  input logic [WORD_W-1:0] rdata
);
  AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    usr_q |-> !irq); // R11
  AST_ENTER_USER: assert property (@(posedge clk) disable iff (rst)
    $rose(usr_q) |-> (!running && !irq)); // R7
  AST_ENTER_CTR: assert property (@(posedge clk) disable iff (rst)
    $fell(usr_q) |-> running); // R8
  AST_CTR_RUNNING: assert property (@(posedge clk) disable iff (rst)
    !usr_q |-> running); // R6
  AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == 2'd1) |=> (rdata[8:0] == 9'd0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R13
endmodule

bind cpu_tmr_chan pct_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .usr_q(usr_q), .irq(irq), .running(running),
  .rd_en(rd_en), .reg_sel(reg_sel), .rdata(rdata)
);

// File: tb/cpu_tmr_chan_tb.sv
module cpu_tmr_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 26;
  // {req[39:36], op[35:34], sel[33:32], data[31:0]}
  localparam logic [39:0] VEC [NV] = '{
    {4'd1,  OP_RD,  2'd0, 32'h0000_0000},  // R1 limit 0
    {4'd1,  OP_RD,  2'd3, 32'h0000_0001},  // R1 running
    {4'd1,  OP_RD,  2'd1, 32'h0000_0000},  // R1 count 0
    {4'd1,  OP_IRQ, 2'd0, 32'h0000_0000},  // R1 irq low
    {4'd4,  OP_WR,  2'd0, 32'h0000_0600},  // R4 limit 3
    {4'd2,  OP_TK,  2'd0, 32'd2},          // R2
    {4'd3,  OP_RD,  2'd1, 32'h0000_0400},  // R3 count 2
    {4'd2,  OP_IRQ, 2'd0, 32'h0000_0000},  // R2
    {4'd2,  OP_TK,  2'd0, 32'd1},          // R2 match
    {4'd2,  OP_IRQ, 2'd0, 32'h0000_0001},  // R2
    {4'd3,  OP_RD,  2'd1, 32'h8000_0000},  // R3 reached, count 0
    {4'd3,  OP_RD,  2'd0, 32'h0000_0600},  // R3 limit read clears
    {4'd3,  OP_IRQ, 2'd0, 32'h0000_0000},  // R3
    {4'd3,  OP_RD,  2'd1, 32'h0000_0000},  // R3
    {4'd6,  OP_WR,  2'd3, 32'h0000_0000},  // R6 ignored
    {4'd6,  OP_RD,  2'd3, 32'h0000_0001},  // R6
    {4'd4,  OP_WR,  2'd1, 32'h1234_5600},  // R4 ignored
    {4'd4,  OP_RD,  2'd1, 32'h0000_0000},  // R4
    {4'd5,  OP_TK,  2'd0, 32'd2},          // R5
    {4'd5,  OP_WR,  2'd2, 32'h0000_0A00},  // R5 limit 5, no reset
    {4'd5,  OP_RD,  2'd1, 32'h0000_0400},  // R5
    {4'd5,  OP_TK,  2'd0, 32'd3},          // R5
    {4'd5,  OP_IRQ, 2'd0, 32'h0000_0001},  // R5
    {4'd2,  OP_RD,  2'd1, 32'h8000_0000},  // R2
    {4'd3,  OP_RD,  2'd0, 32'h0000_0A00},  // R3
    {4'd3,  OP_IRQ, 2'd0, 32'h0000_0000}   // R3
  };

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, user_mode = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, fails = 0;

  cpu_tmr_chan u_dut (
    .clk(clk), .rst(rst), .tick(tick), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic tk);
    wr_en = 1'b1; reg_sel = sel; wdata = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input int req, input logic [1:0] sel, input logic [31:0] exp);
    rd_en = 1'b1; reg_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic set_mode(input logic m);
    user_mode = m;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hang, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][35:34])
        OP_WR:   wr(VEC[v][33:32], VEC[v][31:0], 1'b0);
        OP_RD:   rd(int'(VEC[v][39:36]), VEC[v][33:32], VEC[v][31:0]);
        OP_TK:   tk(int'(VEC[v][31:0]));
        default: check(int'(VEC[v][39:36]), {31'd0, irq}, VEC[v][31:0]);
      endcase
    end

    // R2 free-running with limit 0: no reached, no irq
    wr(2'd0, 32'h0, 1'b0);
    tk(5);
    rd(2, 2'd1, 32'h0000_0A00);   // R2
    check(2, {31'd0, irq}, 32'd0); // R2

    // R7 entry with interrupt pending
    wr(2'd0, 32'h0000_0200, 1'b0);
    tk(1);
    check(2, {31'd0, irq}, 32'd1);
    set_mode(1'b1);
    check(7, {31'd0, irq}, 32'd0);     // R7
    rd(7, 2'd3, 32'd0);                // R7 stopped
    rd(9, 2'd0, 32'h8000_0000);        // R9 reached kept, high word 0

    // R10 load near the top, R6 stopped ignores ticks
    wr(2'd0, 32'h7FFF_FFFF, 1'b0);
    wr(2'd1, 32'hFFFF_FC00, 1'b0);
    rd(10, 2'd0, 32'h7FFF_FFFF);       // R10 reached cleared
    tk(1);
    rd(6, 2'd1, 32'hFFFF_FC00);        // R6 stopped
    wr(2'd3, 32'h1, 1'b0);
    rd(6, 2'd3, 32'd1);                // R6 started
    tk(1);
    rd(11, 2'd1, 32'hFFFF_FE00);       // R11
    tk(1);
    rd(11, 2'd0, 32'h8000_0000);       // R11 wrap sets reached
    rd(11, 2'd1, 32'h0);               // R11
    check(11, {31'd0, irq}, 32'd0);    // R11 no irq

    // R11 carry from low into high half
    wr(2'd0, 32'h0, 1'b0);
    wr(2'd1, 32'hFFFF_FE00, 1'b0);
    tk(1);
    rd(11, 2'd0, 32'h0000_0001);       // R11 carry
    rd(11, 2'd1, 32'h0);

    // R12 load beats same-cycle tick
    wr(2'd1, 32'h0000_0200, 1'b1);
    rd(12, 2'd1, 32'h0000_0200);       // R12

    // R6 stop in user mode
    wr(2'd3, 32'h0, 1'b0);
    tk(2);
    rd(6, 2'd1, 32'h0000_0200);        // R6

    // R8 back to counter mode
    set_mode(1'b0);
    rd(8, 2'd3, 32'd1);                // R8 running
    rd(8, 2'd1, 32'h0);                // R8 count and reached cleared
    rd(7, 2'd0, 32'h7FFF_FE00);        // R7 limit set to max
    tk(2);
    check(13, rdata, 32'h7FFF_FE00);   // R13 hold without read

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule